// File: doc/BRIEF.md
# Multi-Context Receive DMA Sequencer

This block moves received packets out of an on-chip receive packet store into host memory. Several virtual contexts share it. Each context owns a descriptor (a host address and a maximum byte count) and a done word that reports the outcome of its last request. Writing a context's descriptor queues that context. A five-state sequencer (idle, buffer-wait, begin-copy, copying, copy-done) serves queued contexts strictly in arrival order. For each one it issues a single DMA write request on a level request / completion handshake.

A packet longer than one descriptor is delivered in pieces. Each context remembers its own in-progress packet slot, byte offset and remaining count. Its next descriptor continues where the last piece stopped, and the done word flags every non-final piece with a More bit. Other contexts meanwhile take fresh packets. Checksum and packet-type results arrive as sideband flags with each packet and are passed into the done word.

The DMA port is shared with a transmit engine. When a receive copy finishes while the transmit engine waits to start its own copy, the sequencer yields the port until that wait ends. Completion comes either from an external done pulse or from a built-in latency model: a fixed delay plus a per-64-byte factor.

Top module: `rx_dma_seq`

## Requirements
- R1: After reset, or a later reset, the sequencer is idle with no DMA request. Every done word reads zero. The context queue and the packet store are empty, so an earlier descriptor or packet is never served.
- R2: A descriptor write to a context whose done word has Busy (bit 18) clear is accepted. From the next cycle, the done word reads exactly Busy (bit 18 set, all other bits zero).
- R3: A descriptor write to a context whose Busy bit is set pulses `desc_err` for one cycle and is otherwise ignored. The context is not queued again and its stored address and length are unchanged.
- R4: The sequencer leaves idle only while `rx_enable` is high and at least one context is queued. With `rx_enable` low, no DMA request is made.
- R5: A queued context that holds no partial packet waits in buffer-wait until an undelivered packet exists. It then takes the oldest undelivered packet at offset 0.
- R6: Each request carries the descriptor address, a length equal to the smaller of the descriptor length and the packet's remaining bytes, and the packet's store slot and byte offset. These values stay constant while `dma_req` is high.
- R7: A request is not started while `dma_port_busy` is high.
- R8: In latency-model mode, `dma_req` stays high for DELAY + ceil(len/64) x FACTOR + 1 cycles.
- R9: On completion, the done word holds the length in bits [15:0], Complete in bit 16 and the six sideband flags in bits [24:19], with Busy cleared. More (bit 17) is set only when bytes of the packet remain.
- R10: A context whose packet is unfinished resumes that packet at the advanced offset with the reduced remaining count, even when other contexts have taken newer packets in between.
- R11: Queued contexts are served in the order their descriptors were accepted.
- R12: Every completion pulses `ev_rx_dma` for one cycle, one cycle after the copy ends. `ev_rx_empty` pulses with it exactly when freeing a finished packet leaves the store empty.
- R13: If `tx_begin_wait` is high when a receive copy completes, `rx_yield` rises and no new receive request starts until `tx_begin_wait` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Permits the sequencer to leave idle |
| desc_wr_valid | input | 1 | Descriptor write strobe |
| desc_wr_ctx | input | CTX_W | Context index of the write |
| desc_wr_addr | input | ADDR_W | Host address for the copy |
| desc_wr_len | input | 16 | Maximum bytes for the copy |
| desc_err | output | 1 | One-cycle pulse: write to a busy context dropped |
| pkt_push_valid | input | 1 | New packet enters the store |
| pkt_push_len | input | 16 | Byte length of the new packet |
| pkt_push_flags | input | 6 | Packet-type and checksum-error sideband flags |
| pkt_push_ready | output | 1 | Store can accept a packet this cycle |
| stat_rd_ctx | input | CTX_W | Context whose done word is shown |
| stat_rd_data | output | 25 | Done word of the selected context |
| dma_port_busy | input | 1 | Shared DMA port is in use |
| dma_req | output | 1 | DMA write request, high for the whole copy |
| dma_addr | output | ADDR_W | Host address of the copy |
| dma_len | output | 16 | Byte count of the copy |
| dma_slot | output | SLOT_W | Packet store slot being copied |
| dma_offset | output | 16 | Byte offset inside the packet |
| dma_done | input | 1 | External completion pulse (used when the latency model is off) |
| tx_begin_wait | input | 1 | Transmit engine waits to start a copy |
| rx_yield | output | 1 | Receive holds off so transmit takes the port |
| ev_rx_dma | output | 1 | Completion event pulse |
| ev_rx_empty | output | 1 | Store-became-empty event pulse |

## Verification
Several properties are checked on every cycle. An error pulse must follow a descriptor write. Idle may be left only with receive enabled. A request may begin only on a free port, and its address and length stay fixed while it is open. Events come as single pulses two cycles after a copy, the empty event never appears without the completion event, and no request runs under a yield. Other behaviour shows only in the bench scenarios: the exact done-word encodings, the min-length choice, resumed offsets of split packets, first-come ordering across contexts, the latency-model cycle count, and the discarding of queued work by a reset.

// File: rtl/rxd_pkg.sv
// Shared types and done-word field positions for the receive DMA sequencer.
// Assumes a 16-bit length field; other blocks decode the done word by these positions.
package rxd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUFWAIT,
        ST_BEGIN,
        ST_COPY,
        ST_DONE
    } rxd_state_e;

    localparam int LEN_FLD_W    = 16;
    localparam int FLAG_W       = 6;
    localparam int BIT_COMPLETE = 16;
    localparam int BIT_MORE     = 17;
    localparam int BIT_BUSY     = 18;
    localparam int FLAG_LSB     = 19;
    localparam int DONE_W       = FLAG_LSB + FLAG_W;
endpackage

// File: rtl/rxd_ctx_fifo.sv
// In-order queue of context indices awaiting service.
// Assumes each context is queued at most once, so NCTX entries never overflow.
module rxd_ctx_fifo #(
    parameter int NCTX = 4,
    localparam int CTX_W = $clog2(NCTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CTX_W-1:0] push_ctx,
    input  logic             pop,
    output logic [CTX_W-1:0] head,
    output logic [CTX_W:0]   count
);
    logic [CTX_W-1:0] mem_q [NCTX];
    logic [CTX_W-1:0] wr_q, rd_q;
    logic [CTX_W:0]   cnt_q;

    function automatic logic [CTX_W-1:0] bump(input logic [CTX_W-1:0] p);
        return (int'(p) == NCTX - 1) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem_q[rd_q];
    assign count = cnt_q;

    // Pointer, count and storage update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < NCTX; i++) mem_q[i] <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_ctx;
                wr_q        <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + {{CTX_W{1'b0}}, push} - {{CTX_W{1'b0}}, pop};
        end
    end
endmodule

// File: rtl/rxd_pkt_store.sv
// Metadata store of received packets (length and sideband flags per slot).
// Packets are handed out in arrival order but may be freed in any order.
// Assumes the caller takes only when take_avail and frees only occupied slots.
module rxd_pkt_store #(
    parameter int DEPTH  = 4,
    parameter int LEN_W  = 16,
    parameter int FLAG_W = 6,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [FLAG_W-1:0] push_flags,
    output logic              push_ready,
    input  logic              take_en,
    output logic              take_avail,
    output logic [SLOT_W-1:0] take_slot,
    output logic [LEN_W-1:0]  take_len,
    output logic [FLAG_W-1:0] take_flags,
    input  logic              free_en,
    input  logic [SLOT_W-1:0] free_slot,
    output logic              becomes_empty
);
    logic [LEN_W-1:0]  len_q   [DEPTH];
    logic [FLAG_W-1:0] flags_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [SLOT_W-1:0] tail_q, take_q;
    logic [SLOT_W:0]   n_untaken_q, n_valid_q;
    logic              push_fire;

    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Handshake and hand-out view derived from the registered occupancy.
    always_comb begin
        push_ready    = !vld_q[tail_q];
        push_fire     = push_valid && push_ready;
        take_avail    = (n_untaken_q != '0);
        take_slot     = take_q;
        take_len      = len_q[take_q];
        take_flags    = flags_q[take_q];
        becomes_empty = free_en && (n_valid_q == 1) && !push_fire;
    end

    // Slot occupancy, metadata and pointer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q       <= '0;
            tail_q      <= '0;
            take_q      <= '0;
            n_untaken_q <= '0;
            n_valid_q   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                len_q[i]   <= '0;
                flags_q[i] <= '0;
            end
        end else begin
            if (push_fire) begin
                vld_q[tail_q]   <= 1'b1;
                len_q[tail_q]   <= push_len;
                flags_q[tail_q] <= push_flags;
                tail_q          <= bump(tail_q);
            end
            if (free_en) vld_q[free_slot] <= 1'b0;
            if (take_en) take_q <= bump(take_q);
            n_untaken_q <= n_untaken_q + {{SLOT_W{1'b0}}, push_fire} - {{SLOT_W{1'b0}}, take_en};
            n_valid_q   <= n_valid_q + {{SLOT_W{1'b0}}, push_fire} - {{SLOT_W{1'b0}}, free_en};
        end
    end
endmodule

// File: rtl/rxd_lat_timer.sv
// Completion model for the DMA write: done rises DELAY + ceil(len/64)*FACTOR
// cycles after start. Assumes start is not raised while a count is running.
module rxd_lat_timer #(
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 24,
    parameter int DELAY  = 4,
    parameter int FACTOR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q, load;
    logic [LEN_W:0]   blocks;
    logic             act_q;

    // Number of 64-byte blocks, rounded up, and the resulting wait.
    always_comb begin
        blocks = ({1'b0, len} + (LEN_W + 1)'(63)) >> 6;
        load   = CNT_W'(DELAY) + CNT_W'(blocks) * CNT_W'(FACTOR);
        done   = act_q && (cnt_q == '0);
    end

    // Count down from the load value; stop once done has been shown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= load;
        end else if (act_q) begin
            if (cnt_q == '0) act_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rx_dma_seq.sv
// Receive DMA sequencer: serves queued contexts in order, copying packets (or
// pieces of them) from the packet store to host memory over a shared DMA port.
// Assumes dma_done (external mode) pulses only while dma_req is high and that
// the transmit engine raises tx_begin_wait while it waits to start a copy.
module rx_dma_seq #(
    parameter int NCTX       = 4,
    parameter int PKT_DEPTH  = 4,
    parameter int ADDR_W     = 32,
    parameter int LAT_MODEL  = 0,
    parameter int LAT_DELAY  = 4,
    parameter int LAT_FACTOR = 2,
    parameter int CNT_W      = 24,
    localparam int CTX_W     = $clog2(NCTX),
    localparam int SLOT_W    = $clog2(PKT_DEPTH),
    localparam int LEN_W     = rxd_pkg::LEN_FLD_W,
    localparam int FLAG_W    = rxd_pkg::FLAG_W,
    localparam int DONE_W    = rxd_pkg::DONE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              desc_wr_valid,
    input  logic [CTX_W-1:0]  desc_wr_ctx,
    input  logic [ADDR_W-1:0] desc_wr_addr,
    input  logic [LEN_W-1:0]  desc_wr_len,
    output logic              desc_err,
    input  logic              pkt_push_valid,
    input  logic [LEN_W-1:0]  pkt_push_len,
    input  logic [FLAG_W-1:0] pkt_push_flags,
    output logic              pkt_push_ready,
    input  logic [CTX_W-1:0]  stat_rd_ctx,
    output logic [DONE_W-1:0] stat_rd_data,
    input  logic              dma_port_busy,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    output logic [SLOT_W-1:0] dma_slot,
    output logic [LEN_W-1:0]  dma_offset,
    input  logic              dma_done,
    input  logic              tx_begin_wait,
    output logic              rx_yield,
    output logic              ev_rx_dma,
    output logic              ev_rx_empty
);
    import rxd_pkg::*;

    rxd_state_e        state_q;
    logic [DONE_W-1:0] done_q    [NCTX];
    logic [ADDR_W-1:0] d_addr_q  [NCTX];
    logic [LEN_W-1:0]  d_len_q   [NCTX];
    logic [NCTX-1:0]   has_pkt_q;
    logic [SLOT_W-1:0] c_slot_q  [NCTX];
    logic [LEN_W-1:0]  c_off_q   [NCTX];
    logic [LEN_W-1:0]  c_rem_q   [NCTX];
    logic [FLAG_W-1:0] c_flags_q [NCTX];
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  cur_len_q, cur_off_q;
    logic [SLOT_W-1:0] cur_slot_q;
    logic              yield_q, desc_err_q, ev_dma_q, ev_empty_q;

    logic [CTX_W-1:0]  q_head;
    logic [CTX_W:0]    q_count;
    logic              q_push, q_pop, wr_busy;
    logic              take_en, take_avail, free_en, becomes_empty;
    logic [SLOT_W-1:0] take_slot;
    logic [LEN_W-1:0]  take_len, xfer_len;
    logic [FLAG_W-1:0] take_flags;
    logic              start_copy, copy_done, piece_more;

    // Handshake decisions shared by the sequencer and its sub-blocks.
    always_comb begin
        wr_busy    = done_q[desc_wr_ctx][BIT_BUSY];
        q_push     = desc_wr_valid && !wr_busy;
        q_pop      = (state_q == ST_DONE);
        take_en    = (state_q == ST_BUFWAIT) && !has_pkt_q[q_head] && take_avail;
        xfer_len   = (d_len_q[q_head] < c_rem_q[q_head]) ? d_len_q[q_head] : c_rem_q[q_head];
        start_copy = (state_q == ST_BEGIN) && !dma_port_busy && !yield_q;
        piece_more = (c_rem_q[q_head] != cur_len_q);
        free_en    = (state_q == ST_DONE) && !piece_more;
    end

    rxd_ctx_fifo #(.NCTX(NCTX)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_ctx (desc_wr_ctx),
        .pop      (q_pop),
        .head     (q_head),
        .count    (q_count)
    );

    rxd_pkt_store #(.DEPTH(PKT_DEPTH), .LEN_W(LEN_W), .FLAG_W(FLAG_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid    (pkt_push_valid),
        .push_len      (pkt_push_len),
        .push_flags    (pkt_push_flags),
        .push_ready    (pkt_push_ready),
        .take_en       (take_en),
        .take_avail    (take_avail),
        .take_slot     (take_slot),
        .take_len      (take_len),
        .take_flags    (take_flags),
        .free_en       (free_en),
        .free_slot     (c_slot_q[q_head]),
        .becomes_empty (becomes_empty)
    );

    generate
        if (LAT_MODEL != 0) begin : g_lat
            rxd_lat_timer #(
                .LEN_W(LEN_W), .CNT_W(CNT_W), .DELAY(LAT_DELAY), .FACTOR(LAT_FACTOR)
            ) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .start (start_copy),
                .len   (xfer_len),
                .done  (copy_done)
            );
        end else begin : g_ext
            assign copy_done = dma_done;
        end
    endgenerate

    // Sequencer state, per-context registers and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            yield_q    <= 1'b0;
            desc_err_q <= 1'b0;
            ev_dma_q   <= 1'b0;
            ev_empty_q <= 1'b0;
            cur_addr_q <= '0;
            cur_len_q  <= '0;
            cur_off_q  <= '0;
            cur_slot_q <= '0;
            has_pkt_q  <= '0;
            for (int i = 0; i < NCTX; i++) begin
                done_q[i]    <= '0;
                d_addr_q[i]  <= '0;
                d_len_q[i]   <= '0;
                c_slot_q[i]  <= '0;
                c_off_q[i]   <= '0;
                c_rem_q[i]   <= '0;
                c_flags_q[i] <= '0;
            end
        end else begin
            desc_err_q <= desc_wr_valid && wr_busy;
            ev_dma_q   <= 1'b0;
            ev_empty_q <= 1'b0;
            if (q_push) begin
                done_q[desc_wr_ctx]   <= DONE_W'(1) << BIT_BUSY;
                d_addr_q[desc_wr_ctx] <= desc_wr_addr;
                d_len_q[desc_wr_ctx]  <= desc_wr_len;
            end
            if (state_q == ST_DONE && tx_begin_wait) yield_q <= 1'b1;
            else if (!tx_begin_wait)                yield_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (q_count != '0 && rx_enable) state_q <= ST_BUFWAIT;
                end
                ST_BUFWAIT: begin
                    if (has_pkt_q[q_head]) begin
                        state_q <= ST_BEGIN;
                    end else if (take_avail) begin
                        has_pkt_q[q_head] <= 1'b1;
                        c_slot_q[q_head]  <= take_slot;
                        c_off_q[q_head]   <= '0;
                        c_rem_q[q_head]   <= take_len;
                        c_flags_q[q_head] <= take_flags;
                        state_q           <= ST_BEGIN;
                    end
                end
                ST_BEGIN: begin
                    if (start_copy) begin
                        cur_addr_q <= d_addr_q[q_head];
                        cur_len_q  <= xfer_len;
                        cur_off_q  <= c_off_q[q_head];
                        cur_slot_q <= c_slot_q[q_head];
                        state_q    <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (copy_done) state_q <= ST_DONE;
                end
                ST_DONE: begin
                    done_q[q_head] <= {c_flags_q[q_head], 1'b0, piece_more, 1'b1, cur_len_q};
                    if (piece_more) begin
                        c_off_q[q_head] <= c_off_q[q_head] + cur_len_q;
                        c_rem_q[q_head] <= c_rem_q[q_head] - cur_len_q;
                    end else begin
                        has_pkt_q[q_head] <= 1'b0;
                    end
                    ev_dma_q   <= 1'b1;
                    ev_empty_q <= becomes_empty;
                    state_q    <= (q_count > 1 || q_push) ? ST_BUFWAIT : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port view of the registered state.
    always_comb begin
        stat_rd_data = done_q[stat_rd_ctx];
        dma_req      = (state_q == ST_COPY);
        dma_addr     = cur_addr_q;
        dma_len      = cur_len_q;
        dma_slot     = cur_slot_q;
        dma_offset   = cur_off_q;
        desc_err     = desc_err_q;
        rx_yield     = yield_q;
        ev_rx_dma    = ev_dma_q;
        ev_rx_empty  = ev_empty_q;
    end
endmodule

// File: rtl/rxd_seq_checker.sv
// Protocol checker for the receive DMA sequencer, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module rxd_seq_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_enable,
    input logic               desc_wr_valid,
    input logic               desc_err,
    input logic               dma_port_busy,
    input logic               dma_req,
    input logic [ADDR_W-1:0]  dma_addr,
    input logic [LEN_W-1:0]   dma_len,
    input logic               rx_yield,
    input logic               ev_rx_dma,
    input logic               ev_rx_empty,
    input rxd_pkg::rxd_state_e state_q
);
    import rxd_pkg::*;

    // R3: an error pulse always answers a descriptor write one cycle earlier.
    p_err_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> $past(desc_wr_valid));

    // R4: idle is left only while receive is enabled.
    p_idle_exit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) == ST_IDLE) |-> $past(rx_enable));

    // R6: address and length stay fixed while a request is open.
    p_req_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && $past(dma_req)) |-> ($stable(dma_addr) && $stable(dma_len)));

    // R7: a request only begins after a cycle with the shared port free.
    p_start_on_free_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> !$past(dma_port_busy));

    // R12: the completion event follows a copy by two cycles.
    p_event_after_copy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_dma |-> $past(dma_req, 2));

    // R12: the completion event is a single-cycle pulse.
    p_event_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_dma |=> !ev_rx_dma);

    // R12: the empty event only accompanies a completion event.
    p_empty_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_empty |-> ev_rx_dma);

    // R13: no receive copy runs while yielding to transmit.
    p_no_req_in_yield_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rx_yield |-> !dma_req);
endmodule

bind rx_dma_seq rxd_seq_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_enable     (rx_enable),
    .desc_wr_valid (desc_wr_valid),
    .desc_err      (desc_err),
    .dma_port_busy (dma_port_busy),
    .dma_req       (dma_req),
    .dma_addr      (dma_addr),
    .dma_len       (dma_len),
    .rx_yield      (rx_yield),
    .ev_rx_dma     (ev_rx_dma),
    .ev_rx_empty   (ev_rx_empty),
    .state_q       (state_q)
);

// File: tb/rx_dma_seq_test.sv
// Directed bench for the receive DMA sequencer, latency-model mode.
module rx_dma_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCTX = 4;
    localparam int DEPTH = 4;
    localparam int DLY = 2;
    localparam int FAC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        desc_wr_valid = 1'b0;
    logic [1:0]  desc_wr_ctx = '0;
    logic [31:0] desc_wr_addr = '0;
    logic [15:0] desc_wr_len = '0;
    logic        desc_err;
    logic        pkt_push_valid = 1'b0;
    logic [15:0] pkt_push_len = '0;
    logic [5:0]  pkt_push_flags = '0;
    logic        pkt_push_ready;
    logic [1:0]  stat_rd_ctx = '0;
    logic [24:0] stat_rd_data;
    logic        dma_port_busy = 1'b0;
    logic        dma_req;
    logic [31:0] dma_addr;
    logic [15:0] dma_len;
    logic [1:0]  dma_slot;
    logic [15:0] dma_offset;
    logic        tx_begin_wait = 1'b0;
    logic        rx_yield, ev_rx_dma, ev_rx_empty;

    int checks = 0;
    int failures = 0;
    int req_n = 0;
    int n_ev_dma = 0;
    int n_ev_empty = 0;
    logic req_prev = 1'b0;
    int log_addr [32];
    int log_len  [32];
    int log_slot [32];
    int log_off  [32];
    int log_cyc  [32];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_dma_seq #(
        .NCTX(NCTX), .PKT_DEPTH(DEPTH), .ADDR_W(32),
        .LAT_MODEL(1), .LAT_DELAY(DLY), .LAT_FACTOR(FAC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .desc_wr_valid(desc_wr_valid), .desc_wr_ctx(desc_wr_ctx),
        .desc_wr_addr(desc_wr_addr), .desc_wr_len(desc_wr_len), .desc_err(desc_err),
        .pkt_push_valid(pkt_push_valid), .pkt_push_len(pkt_push_len),
        .pkt_push_flags(pkt_push_flags), .pkt_push_ready(pkt_push_ready),
        .stat_rd_ctx(stat_rd_ctx), .stat_rd_data(stat_rd_data),
        .dma_port_busy(dma_port_busy), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_len(dma_len), .dma_slot(dma_slot), .dma_offset(dma_offset),
        .dma_done(1'b0), .tx_begin_wait(tx_begin_wait), .rx_yield(rx_yield),
        .ev_rx_dma(ev_rx_dma), .ev_rx_empty(ev_rx_empty)
    );

    // Log every request and count event pulses, sampled away from the edge.
    always @(negedge clk) begin
        if (dma_req) begin
            if (!req_prev && req_n < 32) begin
                log_addr[req_n] = int'(dma_addr);
                log_len[req_n]  = int'(dma_len);
                log_slot[req_n] = int'(dma_slot);
                log_off[req_n]  = int'(dma_offset);
                log_cyc[req_n]  = 1;
                req_n++;
            end else if (req_prev && req_n > 0) begin
                log_cyc[req_n-1]++;
            end
        end
        req_prev = dma_req;
        if (ev_rx_dma)   n_ev_dma++;
        if (ev_rx_empty) n_ev_empty++;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint done_word(input int flags, input int more, input int len);
        return (longint'(flags) << 19) | (longint'(more) << 17) | (longint'(1) << 16) | longint'(len);
    endfunction

    function automatic longint lat_cycles(input int len);
        return longint'(DLY + ((len + 63) / 64) * FAC + 1);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_desc(input int ctx, input int addr, input int len, output logic err);
        @(negedge clk);
        desc_wr_valid = 1'b1;
        desc_wr_ctx   = 2'(ctx);
        desc_wr_addr  = 32'(addr);
        desc_wr_len   = 16'(len);
        @(negedge clk);
        desc_wr_valid = 1'b0;
        err = desc_err;
    endtask

    task automatic push_pkt(input int len, input int flags);
        @(negedge clk);
        pkt_push_valid = 1'b1;
        pkt_push_len   = 16'(len);
        pkt_push_flags = 6'(flags);
        @(negedge clk);
        pkt_push_valid = 1'b0;
    endtask

    task automatic read_stat(input int ctx, output longint val);
        stat_rd_ctx = 2'(ctx);
        #1;
        val = longint'(stat_rd_data);
    endtask

    task automatic wait_reqs(input int n);
        int t = 0;
        while ((req_n < n || dma_req) && t < 400) begin
            @(negedge clk);
            t++;
        end
        idle(3);
    endtask

    task automatic check_req(input string tag, input int i, input int addr, input int len,
                             input int slot, input int off);
        check({tag, " addr"}, log_addr[i], addr);
        check({tag, " len"},  log_len[i],  len);
        check({tag, " slot"}, log_slot[i], slot);
        check({tag, " offset"}, log_off[i], off);
    endtask

    task automatic t_reset_state();
        longint v;
        check("R1 dma_req after reset", dma_req, 0);
        check("R1 events after reset", ev_rx_dma | ev_rx_empty | desc_err | rx_yield, 0);
        check("R1 push ready after reset", pkt_push_ready, 1);
        for (int c = 0; c < NCTX; c++) begin
            read_stat(c, v);
            check("R1 done word after reset", v, 0);
        end
    endtask

    task automatic t_disabled_and_busy();
        logic   err;
        longint v;
        push_pkt(100, 6'h05);
        write_desc(0, 32'h1000, 256, err);
        check("R2 accepted write no error", err, 0);
        read_stat(0, v);
        check("R2 done word is Busy only", v, longint'(1) << 18);
        idle(20);
        check("R4 no request while disabled", req_n, 0);
        write_desc(0, 32'h2000, 32, err);
        check("R3 error pulse on busy write", err, 1);
        idle(1);
        check("R3 error is one cycle", desc_err, 0);
        read_stat(0, v);
        check("R3 done word unchanged", v, longint'(1) << 18);
        rx_enable = 1'b1;
        wait_reqs(1);
        check_req("R6 first copy", 0, 32'h1000, 100, 0, 0);
        check("R8 latency len 100", log_cyc[0], lat_cycles(100));
        read_stat(0, v);
        check("R9 final done word", v, done_word(6'h05, 0, 100));
        check("R12 completion event", n_ev_dma, 1);
        check("R12 empty event", n_ev_empty, 1);
        idle(20);
        check("R3 dropped write not queued", req_n, 1);
    endtask

    task automatic t_split_packet();
        logic   err;
        longint v;
        write_desc(1, 32'h3000, 64, err);
        idle(15);
        check("R5 waits for a packet", req_n, 1);
        push_pkt(150, 6'h2A);
        wait_reqs(2);
        check_req("R6 first piece", 1, 32'h3000, 64, 1, 0);
        check("R8 latency len 64", log_cyc[1], lat_cycles(64));
        read_stat(1, v);
        check("R9 partial done word with More", v, done_word(6'h2A, 1, 64));
        check("R12 no empty while packet remains", n_ev_empty, 1);
        write_desc(2, 32'h4000, 500, err);
        push_pkt(40, 6'h01);
        wait_reqs(3);
        check_req("R10 other context takes new packet", 2, 32'h4000, 40, 2, 0);
        read_stat(2, v);
        check("R9 short packet done word", v, done_word(6'h01, 0, 40));
        check("R12 store not empty after B", n_ev_empty, 1);
        write_desc(1, 32'h5000, 64, err);
        wait_reqs(4);
        check_req("R10 resume second piece", 3, 32'h5000, 64, 1, 64);
        write_desc(1, 32'h5100, 64, err);
        wait_reqs(5);
        check_req("R10 last piece min length", 4, 32'h5100, 22, 1, 128);
        check("R8 latency len 22", log_cyc[4], lat_cycles(22));
        read_stat(1, v);
        check("R9 last piece done word", v, done_word(6'h2A, 0, 22));
        check("R12 empty after last piece", n_ev_empty, 2);
        check("R12 completion count", n_ev_dma, 5);
    endtask

    task automatic t_order_and_port_busy();
        logic err;
        dma_port_busy = 1'b1;
        push_pkt(10, 0);
        push_pkt(20, 0);
        write_desc(3, 32'h6000, 200, err);
        write_desc(0, 32'h7000, 200, err);
        idle(20);
        check("R7 no request while port busy", req_n, 5);
        dma_port_busy = 1'b0;
        wait_reqs(7);
        check_req("R11 first queued served first", 5, 32'h6000, 10, 3, 0);
        check_req("R11 second queued served second", 6, 32'h7000, 20, 0, 0);
        check("R12 empty after both", n_ev_empty, 3);
    endtask

    task automatic t_tx_priority();
        logic err;
        tx_begin_wait = 1'b1;
        push_pkt(8, 0);
        write_desc(2, 32'h8000, 16, err);
        wait_reqs(8);
        check("R13 yield raised", rx_yield, 1);
        push_pkt(8, 0);
        write_desc(3, 32'h9000, 16, err);
        idle(12);
        check("R13 no request during yield", req_n, 8);
        tx_begin_wait = 1'b0;
        wait_reqs(9);
        check("R13 yield released", rx_yield, 0);
        check("R13 request after release", log_addr[8], 32'h9000);
    endtask

    task automatic t_reset_discard();
        logic   err;
        longint v;
        rx_enable = 1'b0;
        push_pkt(30, 0);
        write_desc(1, 32'hA000, 64, err);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        for (int c = 0; c < NCTX; c++) begin
            read_stat(c, v);
            check("R1 done word after second reset", v, 0);
        end
        rx_enable = 1'b1;
        idle(15);
        check("R1 queue cleared by reset", req_n, 9);
        write_desc(1, 32'hB000, 64, err);
        idle(15);
        check("R1 packet discarded by reset", req_n, 9);
        push_pkt(12, 0);
        wait_reqs(10);
        check_req("R1 fresh packet after reset", 9, 32'hB000, 12, 0, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_state();
        t_disabled_and_busy();
        t_split_packet();
        t_order_and_port_busy();
        t_tx_priority();
        t_reset_discard();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule